// File: doc/BRIEF.md
# Mailbox Transmit Request Arbiter

This block decides which queued message a CAN frame engine sends next. Sixteen receive mailboxes can ask for an automatic reply to a remote frame, and eight transmit mailboxes hold host-queued messages. Each transmit mailbox keeps a request flag, an abort flag and a single-shot marker, and has an interrupt enable. A mode input picks fixed-priority or round-robin order among the transmit mailboxes. Remote-reply requests always go ahead of them.

The frame engine sees a valid selection and accepts it with a one-cycle start acknowledge. The block then holds that choice until the engine returns one outcome: success, arbitration loss or bus error. The outcome updates the mailbox flags. The block then pulses transmit-done, single-shot-failure or remote-reply-clear, as the outcome requires. The host sets request and abort flags through a simple write port. Writing both flags in one write queues a message for a single try, with no retry.

Top module: `tx_req_arbiter`

## Requirements
- R1: When any bit of `rtrReq` is set and no transfer is in flight, `selValid` is 1, `selIsRtr` is 1 and `selIdx` is the lowest set index of `rtrReq`, whatever the transmit flags are.
- R2: With no remote-reply request and `arbMode` = 1 (fixed priority), the selection is the lowest-numbered transmit mailbox whose request flag is set, and `selIsRtr` is 0.
- R3: With no remote-reply request and `arbMode` = 0 (round robin), the selection is the first pending mailbox at or after a rotating pointer, wrapping from 7 to 0. The pointer is 0 after reset. After a successful transmit-mailbox transfer from mailbox k, the pointer becomes k+1, wrapping to 0. Losses and errors leave the pointer unchanged.
- R4: `selValid` is 1 exactly when no transfer is in flight and something is pending. A transfer starts on a cycle with `startAck` and `selValid` both 1. From then until the cycle of `outcomeValid`, `selValid` is 0 and `selIdx`/`selIsRtr` hold the accepted choice. An outcome given while no transfer is in flight is ignored.
- R5: `outcome` encoding: 0 = success, 1 = arbitration loss, 2 or 3 = bus error. For a transmit mailbox, success clears its request, abort and single-shot marker. In the next cycle, `txDoneIrq` pulses for one cycle if `intEn` of that mailbox is 1.
- R6: For a remote-reply transfer, success pulses bit idx of `rtrClr` for one cycle in the next cycle. A loss or error on a remote-reply transfer changes no flag.
- R7: A mailbox with abort set and no single-shot marker loses both request and abort on an arbitration loss. A bus error leaves it pending with abort set.
- R8: A normal mailbox (abort clear) stays pending after an arbitration loss or a bus error and is offered again.
- R9: A single-shot mailbox (request and abort written together) clears its request and keeps abort on a loss or a bus error. In the next cycle, `sstFailIrq` pulses for one cycle. `txDoneIrq` never pulses for such an outcome.
- R10: A host write (`hostWrEn`=1) sets the request and/or abort flag of mailbox `hostWrIdx` and never clears a flag. The new flags are visible on `txReqPend`/`txAbortPend` in the next cycle. If the write comes in the same cycle as an outcome for the same mailbox, the outcome's clearing is applied first and the write's setting wins.
- R11: After reset all flags are clear, `selValid` is 0 and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rtrReq | input | 16 | Remote-reply requests from receive mailboxes |
| intEn | input | 8 | Per-mailbox transmit-done interrupt enable |
| arbMode | input | 1 | 0 round robin, 1 fixed priority |
| hostWrEn | input | 1 | Host flag write strobe |
| hostWrIdx | input | 3 | Mailbox addressed by the host write |
| hostWrReq | input | 1 | Set request flag |
| hostWrAbort | input | 1 | Set abort flag |
| startAck | input | 1 | Frame engine accepts the current selection |
| outcomeValid | input | 1 | Frame engine returns the outcome |
| outcome | input | 2 | 0 success, 1 arbitration loss, 2/3 bus error |
| selValid | output | 1 | A selection is offered |
| selIsRtr | output | 1 | Selection is a remote-reply request |
| selIdx | output | 4 | Index of the selected source |
| txReqPend | output | 8 | Request flags |
| txAbortPend | output | 8 | Abort flags |
| txDoneIrq | output | 1 | One-cycle transmit-done pulse |
| sstFailIrq | output | 1 | One-cycle single-shot failure pulse |
| rtrClr | output | 16 | One-cycle clear for a served remote-reply request |

## Verification
A host write and the frame engine's outcome can land on the same mailbox in the same cycle. The outcome wants to clear flags there, and the write wants to set them. The bench drives the write in the outcome cycle on a random share of transfers, often aimed at the mailbox in flight. It then reads back `txReqPend`/`txAbortPend` after the edge and compares them with a model that applies the outcome first and the write on top. The single-shot marker gets the same treatment, and the next offered selection must agree with the merged flags.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  typedef enum logic [1:0] {
    RES_OK   = 2'b00,
    RES_LOSS = 2'b01,
    RES_ERR  = 2'b10,
    RES_ERRB = 2'b11
  } result_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ok;
    logic loss;
    logic err;
    logic toRtr;
  } upd_t;
endpackage

// File: rtl/tx_arb_ctl.sv
module tx_arb_ctl
  import tx_arb_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            anyPend,
  input  logic            pickIsRtr,
  input  logic [IDXW-1:0] pickIdx,
  input  logic            startAck,
  input  logic            outcomeValid,
  input  logic [1:0]      outcome,
  output logic            selValid,
  output logic            selIsRtr,
  output logic [IDXW-1:0] selIdx,
  output upd_t            upd,
  output logic [IDXW-1:0] updIdx
);
  logic            busy;
  logic            heldRtr;
  logic [IDXW-1:0] heldIdx;
  result_e         res;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      heldRtr <= 1'b0;
      heldIdx <= '0;
    end else if (!busy) begin
      if (startAck && anyPend) begin
        busy    <= 1'b1;
        heldRtr <= pickIsRtr;
        heldIdx <= pickIdx;
      end
    end else if (outcomeValid) begin
      busy <= 1'b0;
    end
  end

  always_comb begin
    res      = result_e'(outcome);
    selValid = !busy && anyPend;
    selIsRtr = busy ? heldRtr : pickIsRtr;
    selIdx   = busy ? heldIdx : pickIdx;
    updIdx   = heldIdx;
    upd      = '0;
    upd.toRtr = heldRtr;
    if (busy && outcomeValid) begin
      unique case (res)
        RES_OK:   upd.ok   = 1'b1;
        RES_LOSS: upd.loss = 1'b1;
        default:  upd.err  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tx_arb_dp.sv
module tx_arb_dp
  import tx_arb_pkg::*;
#(
  parameter int NUM_RTR = 16,
  parameter int NUM_TX  = 8,
  parameter int IDXW    = 4,
  localparam int TXW    = $clog2(NUM_TX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_RTR-1:0] rtrReq,
  input  logic [NUM_TX-1:0]  intEn,
  input  logic               arbMode,
  input  logic               hostWrEn,
  input  logic [TXW-1:0]     hostWrIdx,
  input  logic               hostWrReq,
  input  logic               hostWrAbort,
  input  upd_t               upd,
  input  logic [IDXW-1:0]    updIdx,
  output logic               anyPend,
  output logic               pickIsRtr,
  output logic [IDXW-1:0]    pickIdx,
  output logic [NUM_TX-1:0]  txReqPend,
  output logic [NUM_TX-1:0]  txAbortPend,
  output logic               txDoneIrq,
  output logic               sstFailIrq,
  output logic [NUM_RTR-1:0] rtrClr
);
  logic [NUM_TX-1:0]  reqQ, abortQ, sstQ, reqD, abortD, sstD;
  logic [TXW-1:0]     rrPtr, rrPtrD, fixPick, rrPick;
  logic [IDXW-1:0]    rtrPick;
  logic               rrHit, doneD, failD;
  logic [NUM_RTR-1:0] rtrClrD;

  // selection
  always_comb begin
    anyPend = (|rtrReq) || (|reqQ);
    rtrPick = '0;
    for (int i = NUM_RTR - 1; i >= 0; i--)
      if (rtrReq[i]) rtrPick = IDXW'(i);
    fixPick = '0;
    for (int i = NUM_TX - 1; i >= 0; i--)
      if (reqQ[i]) fixPick = TXW'(i);
    rrPick = '0;
    rrHit  = 1'b0;
    for (int k = 0; k < NUM_TX; k++) begin
      int j;
      j = int'(rrPtr) + k;
      if (j >= NUM_TX) j = j - NUM_TX;
      if (!rrHit && reqQ[j]) begin
        rrPick = TXW'(j);
        rrHit  = 1'b1;
      end
    end
    pickIsRtr = |rtrReq;
    pickIdx   = pickIsRtr ? rtrPick : IDXW'(arbMode ? fixPick : rrPick);
  end

  // flag update: outcome first, host set on top
  always_comb begin
    reqD    = reqQ;
    abortD  = abortQ;
    sstD    = sstQ;
    rrPtrD  = rrPtr;
    doneD   = 1'b0;
    failD   = 1'b0;
    rtrClrD = '0;
    for (int i = 0; i < NUM_RTR; i++)
      if (upd.ok && upd.toRtr && updIdx == IDXW'(i)) rtrClrD[i] = 1'b1;
    for (int i = 0; i < NUM_TX; i++) begin
      if (!upd.toRtr && updIdx == IDXW'(i)) begin
        if (upd.ok) begin
          reqD[i]   = 1'b0;
          abortD[i] = 1'b0;
          sstD[i]   = 1'b0;
          doneD     = intEn[i];
          rrPtrD    = (i == NUM_TX - 1) ? '0 : TXW'(i + 1);
        end else if ((upd.loss || upd.err) && sstQ[i]) begin
          reqD[i] = 1'b0;
          sstD[i] = 1'b0;
          failD   = 1'b1;
        end else if (upd.loss && abortQ[i]) begin
          reqD[i]   = 1'b0;
          abortD[i] = 1'b0;
        end
      end
      if (hostWrEn && hostWrIdx == TXW'(i)) begin
        if (hostWrReq)   reqD[i]   = 1'b1;
        if (hostWrAbort) abortD[i] = 1'b1;
        if (hostWrReq && hostWrAbort) sstD[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ       <= '0;
      abortQ     <= '0;
      sstQ       <= '0;
      rrPtr      <= '0;
      txDoneIrq  <= 1'b0;
      sstFailIrq <= 1'b0;
      rtrClr     <= '0;
    end else begin
      reqQ       <= reqD;
      abortQ     <= abortD;
      sstQ       <= sstD;
      rrPtr      <= rrPtrD;
      txDoneIrq  <= doneD;
      sstFailIrq <= failD;
      rtrClr     <= rtrClrD;
    end
  end

  assign txReqPend   = reqQ;
  assign txAbortPend = abortQ;
endmodule

// File: rtl/tx_req_arbiter.sv
module tx_req_arbiter
  import tx_arb_pkg::*;
#(
  parameter int NUM_RTR = 16,
  parameter int NUM_TX  = 8,
  localparam int TXW    = $clog2(NUM_TX),
  localparam int IDXW   = $clog2((NUM_RTR > NUM_TX) ? NUM_RTR : NUM_TX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_RTR-1:0] rtrReq,
  input  logic [NUM_TX-1:0]  intEn,
  input  logic               arbMode,
  input  logic               hostWrEn,
  input  logic [TXW-1:0]     hostWrIdx,
  input  logic               hostWrReq,
  input  logic               hostWrAbort,
  input  logic               startAck,
  input  logic               outcomeValid,
  input  logic [1:0]         outcome,
  output logic               selValid,
  output logic               selIsRtr,
  output logic [IDXW-1:0]    selIdx,
  output logic [NUM_TX-1:0]  txReqPend,
  output logic [NUM_TX-1:0]  txAbortPend,
  output logic               txDoneIrq,
  output logic               sstFailIrq,
  output logic [NUM_RTR-1:0] rtrClr
);
  upd_t            upd;
  logic [IDXW-1:0] updIdx, pickIdx;
  logic            anyPend, pickIsRtr;

  tx_arb_ctl #(.IDXW(IDXW)) u_ctl (
    .clk(clk), .rstN(rstN), .anyPend(anyPend), .pickIsRtr(pickIsRtr),
    .pickIdx(pickIdx), .startAck(startAck), .outcomeValid(outcomeValid),
    .outcome(outcome), .selValid(selValid), .selIsRtr(selIsRtr),
    .selIdx(selIdx), .upd(upd), .updIdx(updIdx)
  );

  tx_arb_dp #(.NUM_RTR(NUM_RTR), .NUM_TX(NUM_TX), .IDXW(IDXW)) u_dp (
    .clk(clk), .rstN(rstN), .rtrReq(rtrReq), .intEn(intEn), .arbMode(arbMode),
    .hostWrEn(hostWrEn), .hostWrIdx(hostWrIdx), .hostWrReq(hostWrReq),
    .hostWrAbort(hostWrAbort), .upd(upd), .updIdx(updIdx),
    .anyPend(anyPend), .pickIsRtr(pickIsRtr), .pickIdx(pickIdx),
    .txReqPend(txReqPend), .txAbortPend(txAbortPend), .txDoneIrq(txDoneIrq),
    .sstFailIrq(sstFailIrq), .rtrClr(rtrClr)
  );
endmodule

// File: rtl/tx_req_arbiter_chk.sv
module tx_req_arbiter_chk #(
  parameter int NUM_RTR = 16,
  parameter int NUM_TX  = 8,
  parameter int IDXW    = 4,
  localparam int TXW    = $clog2(NUM_TX)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_RTR-1:0] rtrReq,
  input logic               startAck,
  input logic               outcomeValid,
  input logic [1:0]         outcome,
  input logic               selValid,
  input logic               selIsRtr,
  input logic [IDXW-1:0]    selIdx,
  input logic [NUM_TX-1:0]  txReqPend,
  input logic               txDoneIrq,
  input logic               sstFailIrq,
  input logic [NUM_RTR-1:0] rtrClr
);
  logic inFlight;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= 1'b0;
    else if (!inFlight && startAck && selValid) inFlight <= 1'b1;
    else if (inFlight && outcomeValid) inFlight <= 1'b0;
  end

  AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rstN)
    ((startAck && selValid && !inFlight) || (inFlight && !outcomeValid))
      |=> (selIdx == $past(selIdx) && selIsRtr == $past(selIsRtr))); // R4
  AST_QUIET_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !selValid); // R4
  AST_RTR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && (|rtrReq)) |-> selIsRtr); // R1
  AST_TX_PICK_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && !selIsRtr) |-> txReqPend[selIdx[TXW-1:0]]); // R2
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    txDoneIrq |-> $past(inFlight && outcomeValid && outcome == 2'b00 && !selIsRtr)); // R5
  AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    sstFailIrq |-> $past(inFlight && outcomeValid && outcome != 2'b00 && !selIsRtr)); // R9
  AST_RTRCLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rtrClr)); // R6
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(txDoneIrq && sstFailIrq)); // R9
endmodule

bind tx_req_arbiter tx_req_arbiter_chk #(.NUM_RTR(NUM_RTR), .NUM_TX(NUM_TX), .IDXW(IDXW)) u_chk (
  .clk(clk), .rstN(rstN), .rtrReq(rtrReq), .startAck(startAck),
  .outcomeValid(outcomeValid), .outcome(outcome), .selValid(selValid),
  .selIsRtr(selIsRtr), .selIdx(selIdx), .txReqPend(txReqPend),
  .txDoneIrq(txDoneIrq), .sstFailIrq(sstFailIrq), .rtrClr(rtrClr)
);

// File: tb/tx_req_arbiter_bench.sv
module tx_req_arbiter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] rtrReq = '0;
  logic [7:0]  intEn = '0;
  logic        arbMode = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostWrIdx = '0;
  logic        hostWrReq = 1'b0, hostWrAbort = 1'b0;
  logic        startAck = 1'b0, outcomeValid = 1'b0;
  logic [1:0]  outcome = '0;
  logic        selValid, selIsRtr, txDoneIrq, sstFailIrq;
  logic [3:0]  selIdx;
  logic [7:0]  txReqPend, txAbortPend;
  logic [15:0] rtrClr;

  tx_req_arbiter u_tx_req_arbiter (.*);

  always #10 clk = ~clk;

  int nChk = 0, nBad = 0;
  bit [7:0]  mReq = '0, mAbort = '0, mSst = '0;
  bit [15:0] mRtr = '0;
  int        mPtr = 0;

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit anyPend();
    return (mRtr != 0) || (mReq != 0);
  endfunction

  // expected selection: {isRtr, idx}
  function automatic int pick();
    for (int i = 0; i < 16; i++) if (mRtr[i]) return 32'h100 | i;
    if (arbMode) begin
      for (int i = 0; i < 8; i++) if (mReq[i]) return i;
    end else begin
      for (int k = 0; k < 8; k++) if (mReq[(mPtr + k) % 8]) return (mPtr + k) % 8;
    end
    return 0;
  endfunction

  function automatic void hostApply(int idx, bit r, bit a);
    if (r) mReq[idx] = 1'b1;
    if (a) mAbort[idx] = 1'b1;
    if (r && a) mSst[idx] = 1'b1;
  endfunction

  task automatic checkFlags(string req);
    check({req, " req flags"}, txReqPend, mReq);
    check({req, " abort flags"}, txAbortPend, mAbort);
  endtask

  task automatic hostWrite(int idx, bit r, bit a);
    hostWrEn = 1'b1; hostWrIdx = idx[2:0]; hostWrReq = r; hostWrAbort = a;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrReq = 1'b0; hostWrAbort = 1'b0;
    hostApply(idx, r, a);
    checkFlags("R10");
  endtask

  // one full transfer; optional host write in the outcome cycle
  task automatic runTxn(int res, bit co, int cIdx, bit cR, bit cA);
    int p, idx;
    bit isR, expDone, expFail;
    bit [15:0] expClr;
    check("R4 valid", selValid, anyPend());
    if (!anyPend()) return;
    p = pick(); isR = p[8]; idx = p & 8'hff;
    check(isR ? "R1 rtr" : (arbMode ? "R2 kind" : "R3 kind"), selIsRtr, isR);
    check(isR ? "R1 idx" : (arbMode ? "R2 idx" : "R3 idx"), selIdx, idx);
    startAck = 1'b1;
    @(negedge clk);
    startAck = 1'b0;
    check("R4 busy valid", selValid, 0);
    @(negedge clk);
    check("R4 hold idx", selIdx, idx);
    outcomeValid = 1'b1; outcome = res[1:0];
    if (co) begin hostWrEn = 1'b1; hostWrIdx = cIdx[2:0]; hostWrReq = cR; hostWrAbort = cA; end
    @(negedge clk);
    outcomeValid = 1'b0; hostWrEn = 1'b0; hostWrReq = 1'b0; hostWrAbort = 1'b0;
    expDone = 0; expFail = 0; expClr = '0;
    if (isR) begin
      if (res == 0) begin expClr[idx] = 1'b1; mRtr[idx] = 1'b0; end
    end else if (res == 0) begin
      mReq[idx] = 0; mAbort[idx] = 0; mSst[idx] = 0;
      expDone = intEn[idx];
      mPtr = (idx + 1) % 8;
    end else if (mSst[idx]) begin
      mReq[idx] = 0; mSst[idx] = 0; expFail = 1;
    end else if (res == 1 && mAbort[idx]) begin
      mReq[idx] = 0; mAbort[idx] = 0;
    end
    if (co) hostApply(cIdx, cR, cA);
    check("R5 done pulse", txDoneIrq, expDone);
    check("R9 fail pulse", sstFailIrq, expFail);
    check("R6 rtr clear", rtrClr, expClr);
    checkFlags(res == 0 ? "R5" : (co ? "R10" : "R8"));
    rtrReq = mRtr;
    @(negedge clk);
  endtask

  int cyc = 0;
  bit done = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    intEn = 8'hA5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 valid", selValid, 0);
    check("R11 req", txReqPend, 0);
    check("R11 abort", txAbortPend, 0);
    check("R11 pulses", {txDoneIrq, sstFailIrq, |rtrClr}, 0);
    // R3 round robin after success moves pointer
    arbMode = 0;
    hostWrite(5, 1, 0); hostWrite(2, 1, 0);
    runTxn(0, 0, 0, 0, 0);            // serves 2, ptr->3
    hostWrite(0, 1, 0);
    runTxn(0, 0, 0, 0, 0);            // serves 5 (R3)
    runTxn(0, 0, 0, 0, 0);            // serves 0
    // R1 rtr before fixed priority
    arbMode = 1;
    hostWrite(1, 1, 0);
    mRtr = 16'h0840; rtrReq = mRtr; @(negedge clk);
    runTxn(1, 0, 0, 0, 0);            // rtr loss: nothing changes (R6)
    runTxn(0, 0, 0, 0, 0);
    runTxn(0, 0, 0, 0, 0);
    // R9 single shot loss
    hostWrite(3, 1, 1);
    runTxn(0, 0, 0, 0, 0);            // mailbox 1 first
    runTxn(1, 0, 0, 0, 0);            // 3: req clears, abort stays
    // R7 abort: error keeps, loss removes
    hostWrite(4, 1, 0); hostWrite(4, 0, 1);
    runTxn(2, 0, 0, 0, 0);
    runTxn(1, 0, 0, 0, 0);
    // R8 normal loss and error retry
    hostWrite(6, 1, 0);
    runTxn(1, 0, 0, 0, 0);
    runTxn(3, 0, 0, 0, 0);
    // R10 coincident write to the mailbox in flight
    runTxn(0, 1, 6, 1, 0);
    runTxn(1, 1, 6, 1, 1);
    runTxn(2, 1, 6, 1, 1);
    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) hostWrite($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1));
      else if (op == 3) begin
        if ($urandom_range(0, 3) == 0) mRtr[$urandom_range(0, 15)] = 1'b1;
        rtrReq = mRtr; arbMode = $urandom_range(0, 1);
        @(negedge clk);
      end else begin
        bit co;
        co = ($urandom_range(0, 2) == 0);
        runTxn($urandom_range(0, 3), co,
               ($urandom_range(0, 1) ? (selIdx & 7) : $urandom_range(0, 7)),
               $urandom_range(0, 1), $urandom_range(0, 1));
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule